// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block turns eight already-synchronized pin levels into eight independent interrupt request lines. Software chooses, channel by channel, whether the request follows a recorded edge or the current pin level. A small register bus configures it and reads it back. Each channel has its own mode bit, two enable bits and two edge flags, and the block reports a live status word.

In edge mode, a rising or falling transition is recorded in a flag when the matching enable is on. The request stays up until software clears the flag. In level mode, the request follows the pin while it sits at a chosen active level. The second enable bit then holds that active level. A write of 1 to the status register in level mode flips the active level, and the request drops.

Writes and reads are single-cycle. Read data is registered and appears one clock after the read strobe. Request outputs are registered and change two clock edges after a pin change.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq_req` is 0 and `bus_rdata` is 0.
- R2: The mode word at address 0x0 can be read and written. Bit n = 0 puts channel n in edge mode and bit n = 1 puts it in level mode.
- R3: Enable word A (address 0x1) and enable word B (address 0x4) take a full write at their own address. A 1 written to the set alias (A at 0x2, B at 0x5) sets the bit. A 1 written to the clear alias (A at 0x3, B at 0x6) clears the bit. A 0 written to an alias leaves the bit unchanged.
- R4: All alias addresses (0x2, 0x3, 0x5, 0x6, 0x8, 0xA) read back as 0.
- R5: For an edge-mode channel, a 0 to 1 sample sets its rise flag (read at 0x7) only when its A enable is 1. A 1 to 0 sample sets its fall flag (read at 0x9) only when its B enable is 1. Level-mode channels record no edges.
- R6: An edge-mode request is (rise flag AND A enable) OR (fall flag AND B enable). It appears on `irq_req` two rising clock edges after the pin change.
- R7: A 1 written to 0x7 or 0x9 clears that flag bit, and a 1 written to 0x8 or 0xA sets it. A 0 written to any of these addresses has no effect.
- R8: Address 0xB reads the current `irq_req`. A 1 written there for an edge-mode channel clears both of its flags.
- R9: A level-mode channel requests while its A enable is 1 and its pin equals its B bit (1 = active-high, 0 = active-low).
- R10: A 1 written to 0xB for a level-mode channel inverts its B bit, as seen in a read of 0x4, so the request drops.
- R11: When a flag clear (0x7, 0x9 or 0xB) and a newly detected edge hit the same channel in the same cycle, the flag ends up set.
- R12: `bus_rdata` is updated only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_lvl | input | 8 | Synchronized pin levels, one per channel |
| irq_req | output | 8 | Registered request, one per channel |

## Verification
The assertions take for granted that the pin levels are already synchronized to `clk`. They also assume that a write and a read never share a cycle, and that the address is one of the twelve decoded values whenever a strobe is high. The stimulus drives the pins and bus signals only on the falling clock edge. It issues one bus operation at a time, with the strobe low between operations. The same-cycle clash of a flag clear with a fresh edge is produced on purpose, by changing the pin in the cycle of the write.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE     = 4'h0,
    A_ENA      = 4'h1,
    A_ENA_SET  = 4'h2,
    A_ENA_CLR  = 4'h3,
    A_ENB      = 4'h4,
    A_ENB_SET  = 4'h5,
    A_ENB_CLR  = 4'h6,
    A_RISE     = 4'h7,
    A_RISE_SET = 4'h8,
    A_FALL     = 4'h9,
    A_FALL_SET = 4'hA,
    A_STAT     = 4'hB
  } reg_addr_e;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wdata,
  output logic [NCH-1:0]    mode_q,
  output logic [NCH-1:0]    ena_q,
  output logic [NCH-1:0]    enb_q
);
  logic [NCH-1:0] mode_d, ena_d, enb_d;

  always_comb begin
    mode_d = mode_q;
    ena_d  = ena_q;
    enb_d  = enb_q;
    if (wr) begin
      unique case (addr)
        A_MODE:    mode_d = wdata;
        A_ENA:     ena_d  = wdata;
        A_ENA_SET: ena_d  = ena_q | wdata;
        A_ENA_CLR: ena_d  = ena_q & ~wdata;
        A_ENB:     enb_d  = wdata;
        A_ENB_SET: enb_d  = enb_q | wdata;
        A_ENB_CLR: enb_d  = enb_q & ~wdata;
        A_STAT:    enb_d  = enb_q ^ (wdata & mode_q);
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ena_q  <= '0;
      enb_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ena_q  <= ena_d;
      enb_q  <= enb_d;
    end
  end
endmodule

// File: rtl/pic_edge.sv
module pic_edge
  import pic_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    pin_lvl,
  input  logic [NCH-1:0]    mode_q,
  input  logic [NCH-1:0]    ena_q,
  input  logic [NCH-1:0]    enb_q,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wdata,
  output logic [NCH-1:0]    pin_q,
  output logic [NCH-1:0]    rise_q,
  output logic [NCH-1:0]    fall_q
);
  logic [NCH-1:0] stat_clr, rise_clr, fall_clr, rise_set, fall_set;

  always_comb begin
    stat_clr = (wr && addr == A_STAT)     ? (wdata & ~mode_q) : '0;
    rise_clr = ((wr && addr == A_RISE)     ? wdata : '0) | stat_clr;
    fall_clr = ((wr && addr == A_FALL)     ? wdata : '0) | stat_clr;
    rise_set = (wr && addr == A_RISE_SET) ? wdata : '0;
    fall_set = (wr && addr == A_FALL_SET) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_lvl;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic up_ev, dn_ev;
    assign up_ev = ~mode_q[i] & ena_q[i] &  pin_lvl[i] & ~pin_q[i];
    assign dn_ev = ~mode_q[i] & enb_q[i] & ~pin_lvl[i] &  pin_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        rise_q[i] <= 1'b0;
        fall_q[i] <= 1'b0;
      end else begin
        rise_q[i] <= (rise_q[i] & ~rise_clr[i]) | rise_set[i] | up_ev;
        fall_q[i] <= (fall_q[i] & ~fall_clr[i]) | fall_set[i] | dn_ev;
      end
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_q,
  input  logic [NCH-1:0] mode_q,
  input  logic [NCH-1:0] ena_q,
  input  logic [NCH-1:0] enb_q,
  input  logic [NCH-1:0] rise_q,
  input  logic [NCH-1:0] fall_q,
  output logic [NCH-1:0] irq_q
);
  logic [NCH-1:0] edge_req, lvl_req;

  always_comb begin
    edge_req = (rise_q & ena_q) | (fall_q & enb_q);
    lvl_req  = ena_q & ~(pin_q ^ enb_q);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= (mode_q & lvl_req) | (~mode_q & edge_req);
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NCH-1:0]    bus_wdata,
  output logic [NCH-1:0]    bus_rdata,
  input  logic [NCH-1:0]    pin_lvl,
  output logic [NCH-1:0]    irq_req
);
  logic [NCH-1:0] mode_q, ena_q, enb_q, pin_q, rise_q, fall_q, rd_mux;

  pic_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .ena_q(ena_q), .enb_q(enb_q)
  );

  pic_edge #(.NCH(NCH)) u_edge (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .mode_q(mode_q), .ena_q(ena_q),
    .enb_q(enb_q), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pin_q(pin_q), .rise_q(rise_q), .fall_q(fall_q)
  );

  pic_req #(.NCH(NCH)) u_req (
    .clk(clk), .rst(rst), .pin_q(pin_q), .mode_q(mode_q), .ena_q(ena_q),
    .enb_q(enb_q), .rise_q(rise_q), .fall_q(fall_q), .irq_q(irq_req)
  );

  always_comb begin
    unique case (bus_addr)
      A_MODE:  rd_mux = mode_q;
      A_ENA:   rd_mux = ena_q;
      A_ENB:   rd_mux = enb_q;
      A_RISE:  rd_mux = rise_q;
      A_FALL:  rd_mux = fall_q;
      A_STAT:  rd_mux = irq_req;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]    bus_rdata,
  input logic [NCH-1:0]    pin_lvl,
  input logic [NCH-1:0]    irq_req,
  input logic [NCH-1:0]    pin_q,
  input logic [NCH-1:0]    mode_q,
  input logic [NCH-1:0]    ena_q,
  input logic [NCH-1:0]    enb_q,
  input logic [NCH-1:0]    rise_q
);
  logic alias_rd;
  assign alias_rd = bus_rd && (bus_addr == A_ENA_SET || bus_addr == A_ENA_CLR ||
                               bus_addr == A_ENB_SET || bus_addr == A_ENB_CLR ||
                               bus_addr == A_RISE_SET || bus_addr == A_FALL_SET);

  // R4
  alias_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    alias_rd |=> bus_rdata == '0);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R11
  new_rise_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ((pin_lvl & ~pin_q & ena_q & ~mode_q) != '0) |=>
    ((rise_q & $past(pin_lvl & ~pin_q & ena_q & ~mode_q)) ==
     $past(pin_lvl & ~pin_q & ena_q & ~mode_q)));

  // R6
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_req & ~$past(ena_q | enb_q)) == '0));

  // R9
  level_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_req & $past(mode_q & ~ena_q)) == '0));
endmodule

bind pin_irq_ctrl pic_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_lvl(pin_lvl), .irq_req(irq_req),
  .pin_q(pin_q), .mode_q(mode_q), .ena_q(ena_q), .enb_q(enb_q), .rise_q(rise_q)
);

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, pin_lvl = '0, irq_req;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl dut (.*);

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [7:0] e, input string t);
    total++;
    if (irq_req !== e) begin
      bad++;
      $display("FAIL %s: irq=%h expected=%h", t, irq_req, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    step(3);
    rst = 1'b0;
    chk_irq(8'h00, "R1 irq after reset");
    rd(4'h0, 8'h00, "R1 mode reset");
    rd(4'h1, 8'h00, "R1 enA reset");
    rd(4'hB, 8'h00, "R1 status reset");
    // R2
    wr(4'h0, 8'h5A); rd(4'h0, 8'h5A, "R2 mode write");
    wr(4'h0, 8'h00); rd(4'h0, 8'h00, "R2 mode back");
    // R3
    wr(4'h2, 8'h0F); wr(4'h2, 8'h00); rd(4'h1, 8'h0F, "R3 set alias");
    wr(4'h3, 8'h05); rd(4'h1, 8'h0A, "R3 clear alias");
    wr(4'h1, 8'h01); rd(4'h1, 8'h01, "R3 direct write");
    wr(4'h5, 8'h02); wr(4'h6, 8'h00); rd(4'h4, 8'h02, "R3 enB set");
    // R4
    rd(4'h2, 8'h00, "R4 alias A set");
    rd(4'h6, 8'h00, "R4 alias B clr");
    rd(4'h8, 8'h00, "R4 alias rise set");
    // R5 / R6
    @(negedge clk); pin_lvl = 8'h01;
    step(2); chk_irq(8'h01, "R6 rise request");
    rd(4'h7, 8'h01, "R5 rise flag");
    @(negedge clk); pin_lvl = 8'h03;
    step(2); rd(4'h7, 8'h01, "R5 disabled rise ignored");
    @(negedge clk); pin_lvl = 8'h01;
    step(2); chk_irq(8'h03, "R6 fall request");
    rd(4'h9, 8'h02, "R5 fall flag");
    // R8
    wr(4'hB, 8'h01); step(1);
    chk_irq(8'h02, "R8 status clear");
    rd(4'h7, 8'h00, "R8 rise cleared");
    rd(4'h9, 8'h02, "R8 other flag kept");
    rd(4'hB, 8'h02, "R8 status read");
    // R7
    wr(4'h9, 8'h00); rd(4'h9, 8'h02, "R7 zero write");
    wr(4'h9, 8'h02); step(1); chk_irq(8'h00, "R7 fall clear");
    wr(4'h8, 8'h80); rd(4'h7, 8'h80, "R7 rise set");
    chk_irq(8'h00, "R6 flag without enable");
    wr(4'h2, 8'h80); step(1); chk_irq(8'h80, "R6 forced flag enabled");
    wr(4'h7, 8'h80); step(1); chk_irq(8'h00, "R7 rise clear");
    // R11
    @(negedge clk); pin_lvl = 8'h00;
    step(1);
    bus_wr = 1'b1; bus_addr = 4'h7; bus_wdata = 8'h01; pin_lvl = 8'h01;
    @(negedge clk); bus_wr = 1'b0;
    rd(4'h7, 8'h01, "R11 edge beats clear");
    wr(4'hB, 8'h01); step(1); chk_irq(8'h00, "R8 clear after R11");
    // R9
    wr(4'h0, 8'h04); wr(4'h2, 8'h04); step(1);
    chk_irq(8'h04, "R9 active low request");
    wr(4'h5, 8'h04); step(1); chk_irq(8'h00, "R9 active high idle");
    @(negedge clk); pin_lvl = 8'h05;
    step(2); chk_irq(8'h04, "R9 active high request");
    // R10
    wr(4'hB, 8'h04); step(1); chk_irq(8'h00, "R10 toggle drops");
    rd(4'h4, 8'h02, "R10 level bit toggled");
    rd(4'hB, 8'h00, "R10 status read");
    rd(4'h7, 8'h00, "R5 level channel no flag");
    // R12
    rd(4'h1, 8'h85, "R12 read enA");
    held = 8'h85;
    step(3); total++;
    if (bus_rdata !== held) begin
      bad++;
      $display("FAIL R12 hold: rdata=%h expected=%h", bus_rdata, held);
    end
    step(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule